// File: doc/BRIEF.md
# Embedded Word Boundary Serializer

This block turns a 24-bit parallel word into a source-synchronous serial stream on two lines, a bit clock and a data line. Each word is extended by two boundary bits computed from its most significant payload bit. The bit clock carries the word framing: at the end of every word one low clock pulse is left out, so the data line makes a guaranteed transition while the clock stays high. A receiver can find word edges from that condition alone.

The core runs from a free-running reference clock at twice the serial bit rate, so every serial bit time lasts two core cycles: a low half followed by a high half. Words enter through a valid/ready handshake that opens only in the last core cycle of the frame in flight, or at any time when the line is idle. An enable input stops new words from being taken. A power-down input disables the serial outputs at once and abandons any frame in progress.

Top module: `ewb_serializer`

## Requirements
- R1: A frame is 26 bit times of 2 core cycles each; bit times 1 to 24 carry `in_data[0]` up to `in_data[23]` in that order, LSB first.
- R2: Bit time 25 carries the inverse of `in_data[23]`.
- R3: Bit time 26 carries `in_data[23]`, so the data line always toggles between bit times 25 and 26.
- R4: For bit times 1 to 25, `ser_clk` is 0 in the first core cycle and 1 in the second; in bit time 26 the low half is dropped, so `ser_clk` stays 1 for the last three core cycles of the frame. While the outputs are enabled, `ser_dat` changes only when `ser_clk` falls or at the start of bit time 26.
- R5: `in_ready` is 1 only when `en` is 1, `pd` is 0 and either no frame is in flight or the frame is in its last core cycle; a word taken with `in_valid` and `in_ready` both 1 starts its bit time 1 in the next core cycle, so back-to-back words leave no gap.
- R6: With no frame in flight and `pd` at 0, `ser_clk` is 1 and `ser_dat` holds the last bit sent (0 after reset or power-down).
- R7: While `pd` is 1, `ser_oe`, `ser_clk`, `ser_dat` and `in_ready` are 0 and any frame in flight is dropped; after `pd` returns to 0 the line is idle with `ser_dat` at 0.
- R8: While `en` is 0 no word is taken and `in_valid` has no effect; a frame already in flight still finishes.
- R9: After reset, with `en` 1 and `pd` 0: `ser_oe` 1, `ser_clk` 1, `ser_dat` 0, `in_ready` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, twice the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows new words to be taken |
| pd | input | 1 | Power-down: disables serial outputs, drops frame |
| in_valid | input | 1 | Parallel word offered |
| in_ready | output | 1 | Parallel word will be taken this cycle |
| in_data | input | 24 | Parallel payload word |
| ser_clk | output | 1 | Serial bit clock with stretched high at word end |
| ser_dat | output | 1 | Serial data, changes on falling bit clock |
| ser_oe | output | 1 | Output enable for both serial lines (0 = high impedance) |

## Verification
A wrong bit counter shows at the ports within one bit time as a bit clock that falls where it should stay high or a payload bit in the wrong slot, and a wrong frame length shows as the stretched-high window arriving early or late and as `in_ready` opening in the wrong cycle. A corrupted frame register shows in the bit time of the damaged bit, and a wrong boundary rule shows in the last two bit times of the very first word as a missing data toggle. Power-down and idle faults appear in the first core cycle after the control changes, since the outputs depend on the registered state through logic only.

// File: rtl/ewb_pkg.sv
package ewb_pkg;

  localparam int unsigned EWB_PAYLOAD_W = 24;
  localparam int unsigned EWB_EXTRA_BITS = 2;

  typedef struct packed {
    logic clk;
    logic dat;
    logic oe;
  } ser_line_t;

  // Level of the bit clock inside a frame: low half of each bit time,
  // except the final bit time whose low half is suppressed.
  function automatic logic clk_level(input logic second_half,
                                     input logic final_bit);
    return second_half | final_bit;
  endfunction

endpackage

// File: rtl/ewb_frame_build.sv
module ewb_frame_build #(
  parameter int unsigned PAYLOAD_W = ewb_pkg::EWB_PAYLOAD_W,
  localparam int unsigned FRAME_BITS = PAYLOAD_W + ewb_pkg::EWB_EXTRA_BITS
) (
  input  logic [PAYLOAD_W-1:0]  payload,
  output logic [FRAME_BITS-1:0] frame
);

  function automatic logic [FRAME_BITS-1:0] add_boundary(
      input logic [PAYLOAD_W-1:0] w);
    logic top_bit;
    top_bit = w[PAYLOAD_W-1];
    return {top_bit, ~top_bit, w};
  endfunction

  assign frame = add_boundary(payload);

endmodule

// File: rtl/ewb_frame_seq.sv
module ewb_frame_seq #(
  parameter int unsigned FRAME_BITS = 26,
  localparam int unsigned CYCLES = 2 * FRAME_BITS,
  localparam int unsigned CYC_W = $clog2(CYCLES),
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(CYCLES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pd,
  input  logic             load,
  output logic             ready,
  output logic             active,
  output logic [CYC_W-1:0] cyc,
  output logic             last_cyc
);

  assign last_cyc = active && (cyc == LAST_CYC);
  assign ready    = en && !pd && (!active || last_cyc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cyc    <= '0;
    end else if (pd) begin
      active <= 1'b0;
      cyc    <= '0;
    end else if (load) begin
      active <= 1'b1;
      cyc    <= '0;
    end else if (active) begin
      if (last_cyc) begin
        active <= 1'b0;
        cyc    <= '0;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ewb_line_drv.sv
module ewb_line_drv #(
  parameter int unsigned FRAME_BITS = 26,
  localparam int unsigned CYC_W = $clog2(2 * FRAME_BITS),
  localparam int unsigned BIT_W = CYC_W - 1
) (
  input  logic                  pd,
  input  logic                  active,
  input  logic [CYC_W-1:0]      cyc,
  input  logic [FRAME_BITS-1:0] frame_q,
  input  logic                  idle_dat,
  output logic                  final_bit,
  output ewb_pkg::ser_line_t    line
);

  logic [BIT_W-1:0] bit_idx;
  logic             second_half;

  assign bit_idx     = cyc[CYC_W-1:1];
  assign second_half = cyc[0];
  assign final_bit   = active && (bit_idx == BIT_W'(FRAME_BITS - 1));

  always_comb begin
    if (pd) begin
      line = '{clk: 1'b0, dat: 1'b0, oe: 1'b0};
    end else if (active) begin
      line.clk = ewb_pkg::clk_level(second_half, final_bit);
      line.dat = frame_q[bit_idx];
      line.oe  = 1'b1;
    end else begin
      line = '{clk: 1'b1, dat: idle_dat, oe: 1'b1};
    end
  end

endmodule

// File: rtl/ewb_serializer.sv
module ewb_serializer #(
  parameter int unsigned PAYLOAD_W = ewb_pkg::EWB_PAYLOAD_W,
  localparam int unsigned FRAME_BITS = PAYLOAD_W + ewb_pkg::EWB_EXTRA_BITS,
  localparam int unsigned CYC_W = $clog2(2 * FRAME_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 pd,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PAYLOAD_W-1:0] in_data,
  output logic                 ser_clk,
  output logic                 ser_dat,
  output logic                 ser_oe
);

  logic                  accept;
  logic                  active;
  logic [CYC_W-1:0]      cyc;
  logic                  frame_last;
  logic                  final_bit;
  logic [FRAME_BITS-1:0] frame_d;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  idle_dat;
  ewb_pkg::ser_line_t    line;

  assign accept = in_valid && in_ready;

  ewb_frame_build #(.PAYLOAD_W(PAYLOAD_W)) u_build (
    .payload (in_data),
    .frame   (frame_d)
  );

  ewb_frame_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pd       (pd),
    .load     (accept),
    .ready    (in_ready),
    .active   (active),
    .cyc      (cyc),
    .last_cyc (frame_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (accept) begin
      frame_q <= frame_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_dat <= 1'b0;
    end else if (pd) begin
      idle_dat <= 1'b0;
    end else if (frame_last) begin
      idle_dat <= frame_q[FRAME_BITS-1];
    end
  end

  ewb_line_drv #(.FRAME_BITS(FRAME_BITS)) u_drv (
    .pd        (pd),
    .active    (active),
    .cyc       (cyc),
    .frame_q   (frame_q),
    .idle_dat  (idle_dat),
    .final_bit (final_bit),
    .line      (line)
  );

  assign ser_clk = line.clk;
  assign ser_dat = line.dat;
  assign ser_oe  = line.oe;

endmodule

// File: rtl/ewb_serializer_chk.sv
module ewb_serializer_chk #(
  parameter int unsigned CYC_W = 6,
  parameter int unsigned LAST = 51
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd,
  input logic             in_valid,
  input logic             in_ready,
  input logic             ser_clk,
  input logic             ser_dat,
  input logic             ser_oe,
  input logic             active,
  input logic [CYC_W-1:0] cyc,
  input logic             frame_last,
  input logic             final_bit
);

  // R3: data toggles across the boundary bit times
  a_r3_boundary_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cyc == CYC_W'(LAST)) |-> (ser_dat != $past(ser_dat, 2)));

  // R4: clock held high for the final three core cycles of a frame
  a_r4_stretched_high: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cyc >= CYC_W'(LAST - 2)) |-> ser_clk);

  // R4: data moves only with a falling clock or at the last bit time start
  a_r4_data_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && $past(ser_oe) && (ser_dat != $past(ser_dat)))
      |-> (!ser_clk || final_bit));

  // R5: ready opens only when idle or in the last cycle of a frame
  a_r5_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!pd && (!active || frame_last)));

  // R5: a taken word starts with a low clock half in the next cycle
  a_r5_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (active && cyc == '0 && !ser_clk));

  // R6: idle line keeps the clock high
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !pd) |-> (ser_clk && ser_oe));

  // R7: power-down disables everything
  a_r7_pd_off: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> (!ser_oe && !ser_clk && !ser_dat && !in_ready));

endmodule

bind ewb_serializer ewb_serializer_chk #(
  .CYC_W (CYC_W),
  .LAST  (2 * FRAME_BITS - 1)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pd         (pd),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .ser_clk    (ser_clk),
  .ser_dat    (ser_dat),
  .ser_oe     (ser_oe),
  .active     (active),
  .cyc        (cyc),
  .frame_last (frame_last),
  .final_bit  (final_bit)
);

// File: tb/tb_ewb_serializer.sv
module tb_ewb_serializer;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 24;
  localparam int NBITS      = 26;
  localparam int NCYC       = 2 * NBITS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b1;
  logic              pd = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [WORD_W-1:0] in_data = '0;
  logic              ser_clk;
  logic              ser_dat;
  logic              ser_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ewb_serializer dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pd       (pd),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .ser_clk  (ser_clk),
    .ser_dat  (ser_dat),
    .ser_oe   (ser_oe)
  );

  // expected bit clock for core cycle k of a frame
  function automatic logic exp_clk(input int k);
    int b;
    b = k / 2;
    if (b == NBITS - 1) return 1'b1;
    return (k % 2) == 1;
  endfunction

  // expected data for core cycle k of a frame carrying word w
  function automatic logic exp_dat(input logic [WORD_W-1:0] w, input int k);
    int b;
    b = k / 2;
    if (b < WORD_W) return w[b];
    if (b == WORD_W) return !w[WORD_W-1];
    return w[WORD_W-1];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // offers w, waits for it to be taken, checks the whole frame;
  // returns at the sampling point of the last core cycle
  task automatic run_word(input logic [WORD_W-1:0] w, input int drop_en_at);
    in_data  = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < NCYC; k++) begin
      chk(ser_clk == exp_clk(k), "R4 bit clock", ser_clk, exp_clk(k));
      if (k / 2 < WORD_W)
        chk(ser_dat == exp_dat(w, k), "R1 payload bit", ser_dat, exp_dat(w, k));
      else if (k / 2 == WORD_W)
        chk(ser_dat == exp_dat(w, k), "R2 boundary bit 25", ser_dat, exp_dat(w, k));
      else
        chk(ser_dat == exp_dat(w, k), "R3 boundary bit 26", ser_dat, exp_dat(w, k));
      chk(in_ready == (en && k == NCYC - 1), "R5 ready window", in_ready,
          en && k == NCYC - 1);
      if (k == drop_en_at) en = 1'b0;
      if (k < NCYC - 1) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-R actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [WORD_W-1:0] w;
    logic [WORD_W-1:0] last_w;
    void'($urandom(32'h5EED_0C1A));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(ser_oe == 1'b1, "R9 reset oe", ser_oe, 1);
    chk(ser_clk == 1'b1, "R9 reset clk", ser_clk, 1);
    chk(ser_dat == 1'b0, "R9 reset dat", ser_dat, 0);
    chk(in_ready == 1'b1, "R9 reset ready", in_ready, 1);

    // directed corner words, back-to-back (R5 no gap)
    run_word(24'hFFFFFF, -1);
    run_word(24'h555555, -1);
    run_word(24'h000000, -1);
    run_word(24'h800000, -1);
    run_word(24'h7FFFFF, -1);
    last_w = 24'h7FFFFF;

    // R6 idle after a frame: clock high, data holds bit 26
    @(negedge clk);
    repeat (4) begin
      chk(ser_clk == 1'b1, "R6 idle clk", ser_clk, 1);
      chk(ser_dat == last_w[WORD_W-1], "R6 idle dat", ser_dat, last_w[WORD_W-1]);
      chk(in_ready == 1'b1, "R6 idle ready", in_ready, 1);
      @(negedge clk);
    end

    // R8 enable dropped mid-frame: frame finishes, later offers ignored
    w = 24'hA5C3F0;
    run_word(w, 10);
    in_data  = 24'h123456;
    in_valid = 1'b1;
    @(negedge clk);
    repeat (20) begin
      chk(in_ready == 1'b0, "R8 no ready while disabled", in_ready, 0);
      chk(ser_clk == 1'b1, "R8 line stays idle clk", ser_clk, 1);
      chk(ser_dat == w[WORD_W-1], "R8 line stays idle dat", ser_dat, w[WORD_W-1]);
      @(negedge clk);
    end
    in_valid = 1'b0;
    en = 1'b1;
    @(negedge clk);

    // R7 power-down mid-frame
    in_data  = 24'hFEDCBA;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    pd = 1'b1;
    @(negedge clk);
    repeat (3) begin
      chk(ser_oe == 1'b0, "R7 pd oe", ser_oe, 0);
      chk(ser_clk == 1'b0, "R7 pd clk", ser_clk, 0);
      chk(ser_dat == 1'b0, "R7 pd dat", ser_dat, 0);
      chk(in_ready == 1'b0, "R7 pd ready", in_ready, 0);
      @(negedge clk);
    end
    pd = 1'b0;
    @(negedge clk);
    chk(ser_oe == 1'b1, "R7 exit oe", ser_oe, 1);
    chk(ser_clk == 1'b1, "R7 exit idle clk", ser_clk, 1);
    chk(ser_dat == 1'b0, "R7 exit idle dat", ser_dat, 0);
    chk(in_ready == 1'b1, "R7 exit ready", in_ready, 1);

    // random words with random gaps
    for (int i = 0; i < 24; i++) begin
      w = WORD_W'($urandom);
      run_word(w, -1);
      if (($urandom % 3) == 0) begin
        @(negedge clk);
        chk(ser_clk == 1'b1, "R6 gap clk", ser_clk, 1);
        chk(ser_dat == w[WORD_W-1], "R6 gap dat", ser_dat, w[WORD_W-1]);
        repeat ($urandom % 5) @(negedge clk);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule